// File: doc/BRIEF.md
# Serial Audio Input Port (slave receiver)

This block receives stereo audio from a three-wire serial link: a bit clock, a word clock that marks which channel is being sent, and a data line. The block is a slave. All three wires come from an external source and are brought into the system clock domain through synchronizers, where the block detects their edges. One port covers left-justified, I2S-style and right-justified framing. Separate controls set the justification, a one-cell delay of the first data bit, which bit-clock edge samples data, and which word-clock level means left.

Each channel word is emitted as 24 bits, most significant bit first. In the justified modes the word is taken from the start of the channel phase; missing low bits become zero and bits past the 24th are dropped. In right-justified mode the last bits before the word-clock change form the word, and that word is cut to the configured resolution. A left/right pair is presented with a one-cycle valid strobe once the right channel has ended.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rstN` is low, `leftOut`, `rightOut` and `sampleValid` are zero.
- R2: With `cfgJustify`=0 and `cfgDelay`=0, the bit sampled on the first active bit-clock edge after a word-clock change is bit 23 of that channel's word, and later bits fill downward.
- R3: With `cfgJustify`=0 and `cfgDelay`=1, the first active edge of a channel is skipped, and bit 23 is taken on the second active edge.
- R4: In the justified modes, if a channel phase holds fewer than 24 data bits, the bits not received are zero. Data bits after the 24th are ignored.
- R5: With `cfgJustify`=1, the word is the last N bits before the word-clock change, with the last bit as LSB. N is 16 for `cfgRes`=00, 20 for 01, and 24 for 10 or 11. The word is placed in the top N bits of the output, and the lower 24-N bits are zero. `cfgDelay` has no effect in this mode.
- R6: `cfgBclkPol`=0 samples data on rising bit-clock edges; `cfgBclkPol`=1 samples on falling edges.
- R7: `cfgWclkPol`=0 treats a high word clock as the left channel; `cfgWclkPol`=1 treats a low word clock as left.
- R8: `sampleValid` is a single-cycle pulse. It rises on the first active edge of the channel that follows a right channel, and it carries the left and right words of that frame together. The outputs do not change between pulses.
- R9: Data is captured correctly when the bit clock stops between bits, when the two phases have unequal lengths, and for frames of up to 128 bit clocks.
- R10: After reset, no `sampleValid` pulse occurs until both a left channel and the right channel after it have begun with an observed word-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial bit clock (asynchronous) |
| wclkIn | input | 1 | Word clock, selects the channel |
| dataIn | input | 1 | Serial data |
| cfgJustify | input | 1 | 0: word starts at the channel start; 1: word ends at the channel end |
| cfgDelay | input | 1 | Skip one bit cell before the MSB (justified modes only) |
| cfgBclkPol | input | 1 | 0: sample on rising edge; 1: sample on falling edge |
| cfgWclkPol | input | 1 | 0: high means left; 1: low means left |
| cfgRes | input | 2 | Resolution in right-justified mode: 00=16, 01=20, 1x=24 |
| leftOut | output | 24 | Left word, MSB-aligned |
| rightOut | output | 24 | Right word, MSB-aligned |
| sampleValid | output | 1 | One-cycle strobe for a new pair |

## Verification
The assertions assume that the configuration changes only while reset is held. They also assume that each bit-clock level lasts at least two system clocks, so that every edge is seen once and the data is stable around the active edge. The stimulus follows both rules. It holds each bit-clock level for three system cycles, and it only changes the configuration inside a reset window before each test group. Stopped clocks are modelled as extra time at the inactive level, so they never create edges.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int IDX_W = $clog2(SAMPLE_W);

  // Control-to-datapath strobes, valid for one system cycle
  typedef struct packed {
    logic             shift;     // active bit-clock edge seen
    logic             chStart;   // edge opens a new channel phase
    logic             emitOld;   // finished phase must be emitted
    logic             oldRight;  // finished phase was the right channel
    logic             bitVal;    // sampled data bit
    logic             wrEn;      // justified mode: store bit
    logic [IDX_W-1:0] wrIdx;     // 0 = MSB
  } strobe_t;
endpackage

// File: rtl/sai_rx_ctrl.sv
module sai_rx_ctrl
  import sai_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclkIn,
  input  logic    wclkIn,
  input  logic    dataIn,
  input  logic    cfgJustify,
  input  logic    cfgDelay,
  input  logic    cfgBclkPol,
  input  logic    cfgWclkPol,
  output strobe_t strb
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [SYNC_STAGES-1:0] bSh, wSh, dSh;
  logic bPrev, haveLvl, lastLeft, inChan;
  logic [CNT_W-1:0] bitPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSh <= '0;
      wSh <= '0;
      dSh <= '0;
      bPrev <= 1'b0;
    end else begin
      bSh <= {bSh[SYNC_STAGES-2:0], bclkIn};
      wSh <= {wSh[SYNC_STAGES-2:0], wclkIn};
      dSh <= {dSh[SYNC_STAGES-2:0], dataIn};
      bPrev <= bSh[TOP];
    end
  end

  logic activeEdge, levelLeft, change, useDelay;
  logic [CNT_W-1:0] pos, dataIdx;

  always_comb begin
    activeEdge = cfgBclkPol ? (bPrev & ~bSh[TOP]) : (~bPrev & bSh[TOP]);
    levelLeft  = wSh[TOP] ^ cfgWclkPol;
    change     = activeEdge & haveLvl & (levelLeft != lastLeft);
    useDelay   = cfgDelay & ~cfgJustify;
    pos        = change ? '0 : bitPos;
    dataIdx    = pos - CNT_W'(useDelay);

    strb.shift    = activeEdge;
    strb.chStart  = change;
    strb.emitOld  = change & inChan;
    strb.oldRight = ~lastLeft;
    strb.bitVal   = dSh[TOP];
    strb.wrEn     = activeEdge & ~cfgJustify & (pos >= CNT_W'(useDelay))
                    & (dataIdx < CNT_W'(SAMPLE_W));
    strb.wrIdx    = dataIdx[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLvl <= 1'b0;
      lastLeft <= 1'b0;
      inChan <= 1'b0;
      bitPos <= '0;
    end else if (activeEdge) begin
      haveLvl <= 1'b1;
      lastLeft <= levelLeft;
      if (change) inChan <= 1'b1;
      bitPos <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
    end
  end
endmodule

// File: rtl/sai_rx_dp.sv
module sai_rx_dp
  import sai_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                cfgJustify,
  input  logic [1:0]          cfgRes,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);
  logic [SAMPLE_W-1:0] acc, accNext, rjSh, rjWord, word, leftHold;
  logic [IDX_W-1:0] shiftAmt;
  logic leftGood;

  always_comb begin
    case (cfgRes)
      2'b00:   shiftAmt = IDX_W'(SAMPLE_W - 16);
      2'b01:   shiftAmt = IDX_W'(SAMPLE_W - 20);
      default: shiftAmt = '0;
    endcase
    rjWord = rjSh << shiftAmt;
    word = cfgJustify ? rjWord : acc;

    accNext = strb.chStart ? '0 : acc;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (strb.wrEn && strb.wrIdx == IDX_W'(SAMPLE_W - 1 - i)) accNext[i] = strb.bitVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      rjSh <= '0;
      leftHold <= '0;
      leftGood <= 1'b0;
      leftOut <= '0;
      rightOut <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strb.shift) begin
        acc <= accNext;
        rjSh <= strb.chStart ? {{(SAMPLE_W-1){1'b0}}, strb.bitVal}
                             : {rjSh[SAMPLE_W-2:0], strb.bitVal};
      end
      if (strb.emitOld) begin
        if (strb.oldRight) begin
          if (leftGood) begin
            leftOut <= leftHold;
            rightOut <= word;
            sampleValid <= 1'b1;
          end
        end else begin
          leftHold <= word;
          leftGood <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkIn,
  input  logic        wclkIn,
  input  logic        dataIn,
  input  logic        cfgJustify,
  input  logic        cfgDelay,
  input  logic        cfgBclkPol,
  input  logic        cfgWclkPol,
  input  logic [1:0]  cfgRes,
  output logic [23:0] leftOut,
  output logic [23:0] rightOut,
  output logic        sampleValid
);
  strobe_t strb;

  sai_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .wclkIn(wclkIn), .dataIn(dataIn),
    .cfgJustify(cfgJustify), .cfgDelay(cfgDelay), .cfgBclkPol(cfgBclkPol),
    .cfgWclkPol(cfgWclkPol), .strb(strb)
  );

  sai_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgJustify(cfgJustify), .cfgRes(cfgRes),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );
endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgJustify,
  input logic [1:0]  cfgRes,
  input logic [23:0] leftOut,
  input logic [23:0] rightOut,
  input logic        sampleValid
);
  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!sampleValid && leftOut == 24'd0 && rightOut == 24'd0));

  // R8: strobe lasts exactly one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8: outputs only move together with the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R5: right-justified 16-bit words leave the low byte clear
  p_rj16_low_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cfgJustify && cfgRes == 2'b00) |->
      (leftOut[7:0] == 8'd0 && rightOut[7:0] == 8'd0));

  // R5: right-justified 20-bit words leave the low nibble clear
  p_rj20_low_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cfgJustify && cfgRes == 2'b01) |->
      (leftOut[3:0] == 4'd0 && rightOut[3:0] == 4'd0));
endmodule

bind serial_audio_rx sai_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgJustify(cfgJustify), .cfgRes(cfgRes),
  .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic cJust = 1'b0, cDel = 1'b0, cBpol = 1'b0, cWpol = 1'b0;
  logic [1:0] cRes = 2'b10;
  logic [23:0] leftOut, rightOut;
  logic sampleValid;

  int checks = 0, fails = 0;
  int expCnt = 0, rxIdx = 0;
  logic [23:0] expL [0:63];
  logic [23:0] expR [0:63];
  string curTag = "R2";
  logic prevValid = 1'b0;
  localparam int H = 3;

  always #2 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclk), .wclkIn(wclk), .dataIn(sdata),
    .cfgJustify(cJust), .cfgDelay(cDel), .cfgBclkPol(cBpol), .cfgWclkPol(cWpol),
    .cfgRes(cRes), .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int resBits();
    case (cRes)
      2'b00: return 16;
      2'b01: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expWord(input logic [23:0] w, input int n);
    int cap;
    if (cJust) return w << (24 - resBits());
    cap = n - int'(cDel);
    if (cap > 24) cap = 24;
    return w & (24'hFFFFFF << (24 - cap));
  endfunction

  function automatic logic slotBit(input int s, input int n, input logic [23:0] w);
    int idx;
    if (!cJust) begin
      idx = s - int'(cDel);
      if (idx >= 0 && idx < 24) return w[23-idx];
    end else begin
      idx = n - 1 - s;
      if (idx < resBits()) return w[idx];
    end
    return logic'($urandom_range(0, 1));
  endfunction

  task automatic drivePhase(input bit leftCh, input int n, input logic [23:0] w, input bit gaps);
    for (int s = 0; s < n; s++) begin
      bclk = cBpol;
      if (s == 0) wclk = leftCh ^ cWpol;
      sdata = slotBit(s, n, w);
      repeat (H) @(negedge clk);
      if (gaps) repeat ($urandom_range(0, 8)) @(negedge clk);
      bclk = ~cBpol;
      repeat (H) @(negedge clk);
    end
  endtask

  // R8 / all data requirements: compare each presented pair
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid && prevValid) check(1'b0, "R8", "strobe longer than one cycle", 48'd2, 48'd1);
      if (sampleValid) begin
        if (rxIdx < expCnt) begin
          check(leftOut == expL[rxIdx], curTag, "left word", {24'd0, leftOut}, {24'd0, expL[rxIdx]});
          check(rightOut == expR[rxIdx], curTag, "right word", {24'd0, rightOut}, {24'd0, expR[rxIdx]});
        end else begin
          check(1'b0, "R10", "unexpected strobe", 48'(rxIdx), 48'(expCnt));
        end
        rxIdx++;
      end
    end
    prevValid = sampleValid;
  end

  task automatic runTest(input string tag, input bit just, input bit del, input bit bpol,
                         input bit wpol, input logic [1:0] res, input int frames,
                         input int nMin, input int nMax, input bit gaps);
    logic [23:0] wl, wr;
    int nl, nr;
    curTag = tag;
    cJust = just; cDel = del; cBpol = bpol; cWpol = wpol; cRes = res;
    rstN = 1'b0;
    bclk = bpol; wclk = wpol; sdata = 1'b0;
    repeat (6) @(negedge clk);
    // R1: reset state
    check(!sampleValid && leftOut == 24'd0 && rightOut == 24'd0, "R1", "reset outputs",
          {sampleValid, 23'd0, leftOut}, 48'd0);
    expCnt = 0; rxIdx = 0;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // priming frame: not yet a full pair
    drivePhase(1'b1, 24, 24'($urandom), 1'b0);
    drivePhase(1'b0, 24, 24'($urandom), 1'b0);
    check(rxIdx == 0, "R10", "strobe before a complete pair", 48'(rxIdx), 48'd0);
    for (int f = 0; f < frames; f++) begin
      wl = 24'($urandom); wr = 24'($urandom);
      nl = $urandom_range(nMin, nMax);
      nr = $urandom_range(nMin, nMax);
      expL[expCnt] = expWord(wl, nl);
      expR[expCnt] = expWord(wr, nr);
      expCnt++;
      drivePhase(1'b1, nl, wl, gaps);
      drivePhase(1'b0, nr, wr, gaps);
    end
    drivePhase(1'b1, 2, 24'd0, 1'b0);
    repeat (20) @(negedge clk);
    check(rxIdx == expCnt, "R8", {tag, " strobe count"}, 48'(rxIdx), 48'(expCnt));
  endtask

  initial begin
    void'($urandom(32'd4242));
    runTest("R2", 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 6, 24, 40, 1'b0);
    runTest("R3", 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 6, 25, 40, 1'b0);
    runTest("R4", 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 5, 6, 20, 1'b0);
    runTest("R4", 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 4, 40, 64, 1'b0);
    runTest("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 5, 16, 32, 1'b0);
    runTest("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 5, 20, 32, 1'b0);
    runTest("R5", 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 4, 24, 32, 1'b0);
    runTest("R5", 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 4, 24, 30, 1'b0);
    runTest("R6", 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 5, 24, 32, 1'b0);
    runTest("R7", 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 5, 24, 32, 1'b0);
    runTest("R9", 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 5, 10, 64, 1'b1);
    runTest("R9", 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 4, 20, 64, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule